// File: doc/BRIEF.md
# Paged PHY Command Sequencer

This block takes one software-issued PHY management access and carries it onto a management bus. A background polling engine also uses that bus and scans the attached PHYs continuously. Software fills the command fields and sets a run bit. The request then waits until the poller reports that it sits in the gap between two PHY scripts. At that point the sequencer takes the bus and issues a short paged series of transactions. The first selects the page through register 31. The second performs the requested read or write. An optional third write puts 0 back into register 31. The sequencer then releases the bus, and the poller carries on from where it stopped.

The management side is a transaction-level valid/ack interface. Each request is held until the bus layer acknowledges it, and read data comes back in the acknowledge cycle. Turning a request into serial frames is left to a separate bus layer. The page-restore step is chosen by a static configuration pin.

Top module: `phy_cmd_sequencer`

## Requirements
- R1: A command write (`cmd_wr` high) with `cmd_run` set, while idle, makes `cmd_busy` read 1 from the next cycle on. A command write with `cmd_run` clear leaves `cmd_busy` at 0.
- R2: While a command is pending, `bus_own` stays 0 as long as `poll_gap` is 0. `bus_own` becomes 1 in the cycle after a cycle with `poll_gap` at 1. With nothing pending, `poll_gap` does not raise `bus_own`.
- R3: The first transaction after taking the bus is a write (`mgmt_write`=1) to register 31. Its data is the page number, zero-extended to the data width.
- R4: The second transaction goes to the requested register. It is a write of `cmd_wdata` when `cmd_write`=1 and a read (`mgmt_write`=0) when `cmd_write`=0.
- R5: With `cfg_restore_page`=1, a third transaction follows: a write of 0 to register 31.
- R6: With `cfg_restore_page`=0, no transaction follows the register access.
- R7: Every transaction of a command carries the command's PHY address, and `bus_own` returns to 0 in the cycle after the last acknowledge.
- R8: `cmd_busy` falls and `cmd_done` rises in the same cycle, the one after the last acknowledge. `cmd_done` stays 1 until the next accepted run write clears it, and it is 0 while the command is busy.
- R9: For a read, `mgmt_rdata` in the acknowledge cycle of the register access appears on `rd_data` by the time `cmd_done` is 1. Acknowledges of writes never change `rd_data`.
- R10: A run write that arrives while `cmd_busy` is 1 is ignored: the transactions issued carry the fields of the command already accepted.
- R11: While `mgmt_valid` is 1 and `mgmt_ack` is 0, the request and all its fields stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_restore_page | input | 1 | Static: 1 adds a page-0 restore write |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_run | input | 1 | Run bit in the written value |
| cmd_write | input | 1 | 1 = register write, 0 = register read |
| cmd_phy | input | PHY_AW | Target PHY address |
| cmd_reg | input | REG_AW | Target register number |
| cmd_page | input | PW | Page to select |
| cmd_wdata | input | DW | Data for a register write |
| cmd_busy | output | 1 | Run bit readback: pending or executing |
| cmd_done | output | 1 | Last command has completed |
| rd_data | output | DW | Data returned by the last read |
| poll_gap | input | 1 | Poller is between two PHY scripts |
| bus_own | output | 1 | Sequencer holds the bus; poller pauses |
| mgmt_valid | output | 1 | Transaction request |
| mgmt_write | output | 1 | Transaction is a write |
| mgmt_phy | output | PHY_AW | Transaction PHY address |
| mgmt_reg | output | REG_AW | Transaction register number |
| mgmt_wdata | output | DW | Transaction write data |
| mgmt_ack | input | 1 | Transaction finished (one cycle) |
| mgmt_rdata | input | DW | Read data, valid with `mgmt_ack` |

## Verification
Every result lags its cause by exactly one register stage. `cmd_busy` is visible one cycle after the accepted write. `bus_own` and the page-select request appear one cycle after the `poll_gap` cycle. Each later transaction appears one cycle after the acknowledge of the one before it. `cmd_done`, the fall of `cmd_busy` and `rd_data` all follow one cycle after the last acknowledge. The bench changes inputs and samples outputs only on falling edges. Each rising edge therefore separates a stimulus from the cycle in which its result is read. The acknowledge side is held back by 0 to 2 cycles so the bench can observe that pending requests stay stable.

// File: rtl/phy_cmd_sequencer.sv
module phy_cmd_sequencer #(
  parameter int PHY_AW   = 5,
  parameter int REG_AW   = 5,
  parameter int DW       = 16,
  parameter int PW       = 8,
  parameter int PAGE_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_restore_page,
  input  logic              cmd_wr,
  input  logic              cmd_run,
  input  logic              cmd_write,
  input  logic [PHY_AW-1:0] cmd_phy,
  input  logic [REG_AW-1:0] cmd_reg,
  input  logic [PW-1:0]     cmd_page,
  input  logic [DW-1:0]     cmd_wdata,
  output logic              cmd_busy,
  output logic              cmd_done,
  output logic [DW-1:0]     rd_data,
  input  logic              poll_gap,
  output logic              bus_own,
  output logic              mgmt_valid,
  output logic              mgmt_write,
  output logic [PHY_AW-1:0] mgmt_phy,
  output logic [REG_AW-1:0] mgmt_reg,
  output logic [DW-1:0]     mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DW-1:0]     mgmt_rdata
);

  localparam int ZW = DW - PW;
  localparam logic [REG_AW-1:0] PAGE_ADDR = REG_AW'(PAGE_REG);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PAGE, S_ACC, S_REST} state_t;

  state_t              state;
  logic                wr_q;
  logic [PHY_AW-1:0]   phy_q;
  logic [REG_AW-1:0]   reg_q;
  logic [PW-1:0]       page_q;
  logic [DW-1:0]       wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cmd_done <= 1'b0;
      rd_data  <= '0;
      wr_q     <= 1'b0;
      phy_q    <= '0;
      reg_q    <= '0;
      page_q   <= '0;
      wdata_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_wr && cmd_run) begin
          wr_q     <= cmd_write;
          phy_q    <= cmd_phy;
          reg_q    <= cmd_reg;
          page_q   <= cmd_page;
          wdata_q  <= cmd_wdata;
          cmd_done <= 1'b0;
          state    <= S_WAIT;
        end
        S_WAIT: if (poll_gap) state <= S_PAGE;
        S_PAGE: if (mgmt_ack) state <= S_ACC;
        S_ACC: if (mgmt_ack) begin
          if (!wr_q) rd_data <= mgmt_rdata;
          if (cfg_restore_page) state <= S_REST;
          else begin
            state    <= S_IDLE;
            cmd_done <= 1'b1;
          end
        end
        S_REST: if (mgmt_ack) begin
          state    <= S_IDLE;
          cmd_done <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cmd_busy   = (state != S_IDLE);
  assign bus_own    = (state == S_PAGE) || (state == S_ACC) || (state == S_REST);
  assign mgmt_valid = bus_own;
  assign mgmt_write = (state != S_ACC) || wr_q;
  assign mgmt_phy   = phy_q;
  assign mgmt_reg   = (state == S_ACC) ? reg_q : PAGE_ADDR;
  assign mgmt_wdata = (state == S_PAGE) ? {{ZW{1'b0}}, page_q} :
                      (state == S_ACC)  ? wdata_q : '0;

  // R2
  gap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> $past(poll_gap));

  // R3
  page_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> (mgmt_valid && mgmt_write && mgmt_reg == PAGE_ADDR));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_valid && !mgmt_ack) |=> (mgmt_valid && $stable(mgmt_write) &&
      $stable(mgmt_reg) && $stable(mgmt_wdata) && $stable(mgmt_phy)));

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_busy) |-> (cmd_done && !bus_own));

  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !cmd_done);

  // R10
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && $past(cmd_busy)) |-> $stable(mgmt_phy));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mgmt_ack) |-> $stable(rd_data));

endmodule

// File: tb/phy_cmd_sequencer_test.sv
`timescale 1ns/1ps
module phy_cmd_sequencer_test;

  typedef struct {
    logic        w;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] data;
    logic [15:0] rdata;
    string       tag;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_restore_page = 1'b1;
  logic        cmd_wr = 1'b0, cmd_run = 1'b0, cmd_write = 1'b0;
  logic [4:0]  cmd_phy = '0, cmd_reg = '0;
  logic [7:0]  cmd_page = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_busy, cmd_done, bus_own, mgmt_valid, mgmt_write;
  logic [15:0] rd_data, mgmt_wdata;
  logic        poll_gap = 1'b0;
  logic [4:0]  mgmt_phy, mgmt_reg;
  logic        mgmt_ack = 1'b0;
  logic [15:0] mgmt_rdata = '0;

  int tests = 0, fails = 0, ack_lat = 0;
  op_t exp_q[$];

  always #2.5 clk = ~clk;

  phy_cmd_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_restore_page(cfg_restore_page),
    .cmd_wr(cmd_wr), .cmd_run(cmd_run), .cmd_write(cmd_write),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_page(cmd_page),
    .cmd_wdata(cmd_wdata), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
    .rd_data(rd_data), .poll_gap(poll_gap), .bus_own(bus_own),
    .mgmt_valid(mgmt_valid), .mgmt_write(mgmt_write), .mgmt_phy(mgmt_phy),
    .mgmt_reg(mgmt_reg), .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack),
    .mgmt_rdata(mgmt_rdata));

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_op(input op_t it, input string when);
    chk(mgmt_write == it.w, {it.tag, " write flag ", when}, 32'(mgmt_write), 32'(it.w));
    chk(mgmt_phy == it.phy, {"R7 phy ", when}, 32'(mgmt_phy), 32'(it.phy));
    chk(mgmt_reg == it.rg, {it.tag, " reg ", when}, 32'(mgmt_reg), 32'(it.rg));
    if (it.w)
      chk(mgmt_wdata == it.data, {it.tag, " data ", when}, 32'(mgmt_wdata), 32'(it.data));
  endtask

  // monitor: pops the expected transaction and acknowledges it
  initial begin
    forever begin
      @(negedge clk);
      if (mgmt_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected transaction", 32'(mgmt_reg), 32'h0);
          mgmt_rdata = 16'hDEAD;
        end else begin
          op_t it;
          it = exp_q.pop_front();
          cmp_op(it, "at request");
          for (int i = 0; i < ack_lat; i++) @(negedge clk);
          if (ack_lat > 0) cmp_op(it, "R11 held");
          mgmt_rdata = it.rdata;
        end
        mgmt_ack = 1'b1;
        @(negedge clk);
        mgmt_ack = 1'b0;
      end
    end
  end

  task automatic run_cmd(input logic w, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [7:0] page, input logic [15:0] wd,
                         input logic [15:0] rd, input logic restore,
                         input int gap_dly, input int lat, input bit poke);
    op_t it;
    logic [15:0] prev_rd = rd_data;
    cfg_restore_page = restore;
    ack_lat = lat;
    it = '{1'b1, phy, 5'd31, {8'h00, page}, 16'hDEAD, "R3"};
    exp_q.push_back(it);
    it = '{w, phy, rg, wd, (w ? 16'hDEAD : rd), "R4"};
    exp_q.push_back(it);
    if (restore) begin
      it = '{1'b1, phy, 5'd31, 16'h0000, 16'hDEAD, "R5"};
      exp_q.push_back(it);
    end
    @(negedge clk);
    cmd_wr = 1'b1; cmd_run = 1'b1; cmd_write = w; cmd_phy = phy;
    cmd_reg = rg; cmd_page = page; cmd_wdata = wd;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_busy == 1'b1, "R1 busy after run write", 32'(cmd_busy), 32'h1);
    chk(cmd_done == 1'b0, "R8 done cleared on accept", 32'(cmd_done), 32'h0);
    if (poke) begin
      // R10: second run write while busy, all fields different
      cmd_wr = 1'b1; cmd_write = ~w; cmd_phy = phy ^ 5'h1;
      cmd_reg = rg ^ 5'h3; cmd_page = page + 8'd1; cmd_wdata = ~wd;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(cmd_busy == 1'b1, "R10 still busy", 32'(cmd_busy), 32'h1);
    end
    for (int i = 0; i < gap_dly; i++) begin
      chk(bus_own == 1'b0, "R2 no bus without gap", 32'(bus_own), 32'h0);
      @(negedge clk);
    end
    poll_gap = 1'b1;
    @(negedge clk);
    poll_gap = 1'b0;
    chk(bus_own == 1'b1, "R2 bus taken after gap", 32'(bus_own), 32'h1);
    for (int i = 0; i < 60 && cmd_busy; i++) begin
      if (cmd_done) chk(1'b0, "R8 done while busy", 32'(cmd_done), 32'h0);
      @(negedge clk);
    end
    chk(cmd_busy == 1'b0, "R8 busy cleared", 32'(cmd_busy), 32'h0);
    chk(cmd_done == 1'b1, "R8 done with busy fall", 32'(cmd_done), 32'h1);
    chk(bus_own == 1'b0, "R7 bus released", 32'(bus_own), 32'h0);
    chk(exp_q.size() == 0, restore ? "R5 all steps issued" : "R6 all steps issued",
        32'(exp_q.size()), 32'h0);
    if (!w) chk(rd_data == rd, "R9 read data", 32'(rd_data), 32'(rd));
    else    chk(rd_data == prev_rd, "R9 write keeps rd_data", 32'(rd_data), 32'(prev_rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_busy == 1'b0, "R1 reset busy", 32'(cmd_busy), 32'h0);
    chk(cmd_done == 1'b0, "R8 reset done", 32'(cmd_done), 32'h0);
    chk(bus_own == 1'b0, "R7 reset bus", 32'(bus_own), 32'h0);
    chk(rd_data == 16'h0, "R9 reset rd_data", 32'(rd_data), 32'h0);

    // write without run bit, then a gap with nothing pending
    cmd_wr = 1'b1; cmd_run = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(cmd_busy == 1'b0, "R1 no run bit", 32'(cmd_busy), 32'h0);
    poll_gap = 1'b1;
    @(negedge clk);
    poll_gap = 1'b0;
    chk(bus_own == 1'b0, "R2 gap with nothing pending", 32'(bus_own), 32'h0);

    run_cmd(1'b1, 5'd3, 5'd9, 8'h2A, 16'h1234, 16'h0, 1'b1, 5, 0, 1'b0);
    run_cmd(1'b0, 5'd7, 5'd16, 8'h05, 16'h0, 16'hBEEF, 1'b1, 2, 2, 1'b0);
    run_cmd(1'b0, 5'd12, 5'd4, 8'h81, 16'h0, 16'h5A5A, 1'b0, 4, 1, 1'b1);
    run_cmd(1'b1, 5'd31, 5'd0, 8'hFF, 16'hFFFF, 16'h0, 1'b0, 0, 0, 1'b0);

    repeat (5) @(negedge clk);
    chk(cmd_done == 1'b1, "R8 done persists", 32'(cmd_done), 32'h1);
    chk(rd_data == 16'h5A5A, "R9 rd_data kept", 32'(rd_data), 32'h5A5A);

    run_cmd(1'b1, 5'd0, 5'd13, 8'h00, 16'hA5C3, 16'h0, 1'b1, 1, 1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule